// File: doc/BRIEF.md
# Electrically Erasable EPROM Programming Sequencer

This block is a sequencer that runs the pins of one or more parallel, electrically erasable EPROMs. It can erase a whole array and check the result, or program a run of bytes and check each one. A host gives it a command: the operation, a start address, a byte count and a mask of target chips. For a program command it then sends the bytes one at a time over a valid/ready stream. When the job ends the sequencer pulses `done`. `pass` tells whether every check succeeded, and `fail_addr` gives the first address that did not read back correctly.

On the device side the block drives the active-low chip enables (one per chip), the shared output enable, the program strobe, the address bus and a tri-state data bus. It does not switch the high programming supply or the elevated identification level on address line 9 itself. It raises logic-level requests for them and waits for a single acknowledge before it pulses the strobe. Several chips can be erased or programmed together, because every chip sees the same address, data and strobe lines. Verify reads go to one chip at a time, so the chips never share the data bus during a read.

States: `ST_IDLE`, `ST_ER_RAMP`, `ST_ER_PULSE`, `ST_ER_SETTLE`, `ST_ER_VFY`, `ST_PG_RAMP`, `ST_PG_FETCH`, `ST_PG_SETUP`, `ST_PG_PULSE`, `ST_PG_SETTLE`, `ST_PG_VFY`, `ST_RAMPDN`, `ST_DONE`.

Transitions:
- From `ST_IDLE`, an accepted command goes to one of three states:
  - `ST_RAMPDN` for a no-op command.
  - `ST_ER_RAMP` for an erase.
  - `ST_PG_RAMP` for a program.
- Erase path:
  - `ST_ER_RAMP` goes to `ST_ER_PULSE` on acknowledge.
  - `ST_ER_PULSE` goes to `ST_ER_SETTLE` when the pulse timer ends.
  - `ST_ER_SETTLE` goes to `ST_ER_VFY`.
  - `ST_ER_VFY` loops over every chip at every address. It goes to `ST_RAMPDN` on a mismatch or after the last read.
- Program path:
  - `ST_PG_RAMP` goes to `ST_PG_FETCH` on acknowledge.
  - `ST_PG_FETCH` goes to `ST_PG_SETUP` on a stream byte.
  - `ST_PG_SETUP` goes to `ST_PG_PULSE`.
  - `ST_PG_PULSE` goes to `ST_PG_SETTLE` when the timer ends.
  - `ST_PG_SETTLE` goes to `ST_PG_VFY`.
  - `ST_PG_VFY` loops over the chips. It then returns to `ST_PG_FETCH`, or goes to `ST_RAMPDN` on a mismatch or after the last byte.
- Ending:
  - `ST_RAMPDN` goes to `ST_DONE` once the acknowledge has dropped.
  - `ST_DONE` goes to `ST_IDLE`.

Top module: `eprom_prog_seq`

## Requirements
- R1: While the erase strobe is low, all of the following hold:
  - the supply request and the A9 high-level request are both raised;
  - output enable is high;
  - the address bus is all zeros;
  - the data bus is driven to all ones;
  - the chip enable of every chip in the mask is low.
  The A9 request is never raised without the supply request.
- R2: The erase strobe stays low for exactly ERASE_CYC cycles, and each program strobe stays low for exactly PROG_CYC cycles. Each program byte gets one strobe.
- R3: After an erase, every selected chip is read at every address from 0 up to the top address. Each byte must read 0xFF.
- R4: Program byte i is written to address start+i on all selected chips. Each chip is then read back at that address, and the value must equal the byte.
- R5: During a verify read, all of the following hold:
  - output enable is low;
  - the strobe is high;
  - exactly one chip enable is low.
  The read is sampled only after output enable and the address have stayed stable for ACC_CYC+1 cycles.
- R6: The block never drives the data bus while output enable is low.
- R7: A chip whose mask bit is 0 never sees its chip enable go low, so its contents stay unchanged.
- R8: On a verify mismatch, the block records the address in `fail_addr` and clears `pass`. It does not retry, and it accepts no further stream bytes.
- R9: Both high-level requests are low when `done` pulses. `done` is high for exactly one cycle.
- R10: The program strobe goes low only while the supply request and the acknowledge are both high.
- R11: Two commands do nothing: a program command with a byte count of 0, and any command with an all-zero chip mask. Either one ends with `pass`=1, raises no request and gives no strobe.
- R12: Out of reset, all of the following hold:
  - `cmd_ready` is 1 and `done` is 0;
  - the strobe, output enable and every chip enable are high;
  - both requests are low.
- R13: `cmd_ready` is high only in the idle state. During that time every chip enable and the strobe are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, takes a command |
| cmd_op | input | 1 | 0 = erase whole array, 1 = program bytes |
| cmd_addr | input | ADDR_W | Start address for program |
| cmd_len | input | ADDR_W+1 | Number of bytes to program |
| cmd_chips | input | NUM_CHIPS | Mask of target chips |
| wr_valid | input | 1 | Program byte offered |
| wr_ready | output | 1 | Program byte taken |
| wr_data | input | DATA_W | Program byte |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | 1 when every verify matched |
| fail_addr | output | ADDR_W | First mismatching address |
| dev_ce_n | output | NUM_CHIPS | Per-chip enable, active low |
| dev_oe_n | output | 1 | Shared output enable, active low |
| dev_pgm_n | output | 1 | Shared program/erase strobe, active low |
| dev_addr | output | ADDR_W | Shared address bus |
| dev_data | inout | DATA_W | Shared data bus |
| vpp_req | output | 1 | Request for the high programming supply |
| a9hv_req | output | 1 | Request for the high level on address line 9 |
| hv_ack | input | 1 | Requested high levels are present |

## Verification
The assertions check the pin relationships on every cycle. These are:
- the erase pin pattern while the strobe is low;
- the strobe only firing while the supply is acknowledged;
- exactly one enabled chip and a released bus during reads;
- chip enables staying inside the mask;
- requests low at `done`.

Other behaviours can only be shown by the bench's scenarios:
- pulse widths;
- array contents after erase and program;
- the bits-only-clear effect that makes programming over written data fail;
- the first failing address and the stop without retry;
- the no-op commands;
- the access wait. The device model returns wrong data until output enable has been stable long enough.

// File: rtl/eprom_seq_pkg.sv
package eprom_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ER_RAMP,
        ST_ER_PULSE,
        ST_ER_SETTLE,
        ST_ER_VFY,
        ST_PG_RAMP,
        ST_PG_FETCH,
        ST_PG_SETUP,
        ST_PG_PULSE,
        ST_PG_SETTLE,
        ST_PG_VFY,
        ST_RAMPDN,
        ST_DONE
    } seq_state_t;

    localparam logic OP_ERASE   = 1'b0;
    localparam logic OP_PROGRAM = 1'b1;

endpackage

// File: rtl/eprom_seq_timer.sv
module eprom_seq_timer #(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    output logic             expired
);

    logic [TMR_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/eprom_seq_chipsel.sv
module eprom_seq_chipsel #(
    parameter int NUM_CHIPS = 2,
    parameter int CHIP_W    = 1
) (
    input  logic [NUM_CHIPS-1:0] mask,
    input  logic [CHIP_W-1:0]    cur,
    output logic [CHIP_W-1:0]    first_idx,
    output logic [CHIP_W-1:0]    next_idx,
    output logic                 is_last
);

    always_comb begin
        first_idx = '0;
        next_idx  = '0;
        is_last   = 1'b1;
        for (int i = NUM_CHIPS - 1; i >= 0; i--) begin
            if (mask[i])
                first_idx = CHIP_W'(i);
            if (mask[i] && (i > int'(cur))) begin
                next_idx = CHIP_W'(i);
                is_last  = 1'b0;
            end
        end
    end

endmodule

// File: rtl/eprom_prog_seq.sv
module eprom_prog_seq
    import eprom_seq_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int DATA_W    = 8,
    parameter int NUM_CHIPS = 2,
    parameter int CLK_HZ    = 100_000_000,
    parameter int ERASE_CYC = CLK_HZ / 10,
    parameter int PROG_CYC  = CLK_HZ / 10_000,
    parameter int ACC_CYC   = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    output logic                 cmd_ready,
    input  logic                 cmd_op,
    input  logic [ADDR_W-1:0]    cmd_addr,
    input  logic [ADDR_W:0]      cmd_len,
    input  logic [NUM_CHIPS-1:0] cmd_chips,
    input  logic                 wr_valid,
    output logic                 wr_ready,
    input  logic [DATA_W-1:0]    wr_data,
    output logic                 done,
    output logic                 pass,
    output logic [ADDR_W-1:0]    fail_addr,
    output logic [NUM_CHIPS-1:0] dev_ce_n,
    output logic                 dev_oe_n,
    output logic                 dev_pgm_n,
    output logic [ADDR_W-1:0]    dev_addr,
    inout  wire  [DATA_W-1:0]    dev_data,
    output logic                 vpp_req,
    output logic                 a9hv_req,
    input  logic                 hv_ack
);

    localparam int LEN_W  = ADDR_W + 1;
    localparam int CHIP_W = (NUM_CHIPS > 1) ? $clog2(NUM_CHIPS) : 1;
    localparam int MAX_PE = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int MAX_C  = (MAX_PE > ACC_CYC) ? MAX_PE : ACC_CYC;
    localparam int TMR_W  = $clog2(MAX_C + 1);

    seq_state_t st_q, st_d;

    logic [ADDR_W-1:0]    addr_q;
    logic [LEN_W-1:0]     left_q;
    logic [NUM_CHIPS-1:0] mask_q;
    logic [CHIP_W-1:0]    chip_q;
    logic [DATA_W-1:0]    byte_q;
    logic                 pass_q;
    logic [ADDR_W-1:0]    fail_q;

    logic                 tmr_load, tmr_done;
    logic [TMR_W-1:0]     tmr_val;
    logic [CHIP_W-1:0]    first_c, next_c;
    logic                 last_c;
    logic                 in_vfy, vfy_hit, vfy_ok;
    logic                 drv_en;
    logic [DATA_W-1:0]    dout;
    logic [DATA_W-1:0]    expect_v;
    logic                 noop_cmd;

    eprom_seq_timer #(.TMR_W(TMR_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    eprom_seq_chipsel #(.NUM_CHIPS(NUM_CHIPS), .CHIP_W(CHIP_W)) u_sel (
        .mask      (mask_q),
        .cur       (chip_q),
        .first_idx (first_c),
        .next_idx  (next_c),
        .is_last   (last_c)
    );

    assign in_vfy   = (st_q == ST_ER_VFY) || (st_q == ST_PG_VFY);
    assign vfy_hit  = in_vfy && tmr_done;
    assign expect_v = (st_q == ST_ER_VFY) ? {DATA_W{1'b1}} : byte_q;
    assign vfy_ok   = (dev_data == expect_v);
    assign noop_cmd = (cmd_chips == '0) || ((cmd_op == OP_PROGRAM) && (cmd_len == '0));

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:
                if (cmd_valid) begin
                    if (noop_cmd)                 st_d = ST_RAMPDN;
                    else if (cmd_op == OP_PROGRAM) st_d = ST_PG_RAMP;
                    else                          st_d = ST_ER_RAMP;
                end
            ST_ER_RAMP:   if (hv_ack)   st_d = ST_ER_PULSE;
            ST_ER_PULSE:  if (tmr_done) st_d = ST_ER_SETTLE;
            ST_ER_SETTLE:               st_d = ST_ER_VFY;
            ST_ER_VFY:
                if (tmr_done) begin
                    if (!vfy_ok)                        st_d = ST_RAMPDN;
                    else if (last_c && (addr_q == '1))  st_d = ST_RAMPDN;
                end
            ST_PG_RAMP:   if (hv_ack)   st_d = ST_PG_FETCH;
            ST_PG_FETCH:  if (wr_valid) st_d = ST_PG_SETUP;
            ST_PG_SETUP:                st_d = ST_PG_PULSE;
            ST_PG_PULSE:  if (tmr_done) st_d = ST_PG_SETTLE;
            ST_PG_SETTLE:               st_d = ST_PG_VFY;
            ST_PG_VFY:
                if (tmr_done) begin
                    if (!vfy_ok)                   st_d = ST_RAMPDN;
                    else if (last_c)
                        st_d = (left_q == LEN_W'(1)) ? ST_RAMPDN : ST_PG_FETCH;
                end
            ST_RAMPDN:    if (!hv_ack)  st_d = ST_DONE;
            ST_DONE:                    st_d = ST_IDLE;
            default:                    st_d = ST_IDLE;
        endcase
    end

    // timer restart on every state change and on every further read in a verify loop
    assign tmr_load = (st_d != st_q) || (vfy_hit && (st_d == st_q));

    always_comb begin
        unique case (st_d)
            ST_ER_PULSE: tmr_val = TMR_W'(ERASE_CYC - 1);
            ST_PG_PULSE: tmr_val = TMR_W'(PROG_CYC - 1);
            ST_ER_VFY,
            ST_PG_VFY:   tmr_val = TMR_W'(ACC_CYC);
            default:     tmr_val = '0;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // job datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            left_q <= '0;
            mask_q <= '0;
            chip_q <= '0;
            byte_q <= '0;
            pass_q <= 1'b0;
            fail_q <= '0;
        end else begin
            if ((st_q == ST_IDLE) && cmd_valid) begin
                addr_q <= (cmd_op == OP_PROGRAM) ? cmd_addr : '0;
                left_q <= cmd_len;
                mask_q <= cmd_chips;
                pass_q <= 1'b1;
                fail_q <= '0;
            end
            if ((st_q == ST_ER_SETTLE) || (st_q == ST_PG_SETTLE))
                chip_q <= first_c;
            if ((st_q == ST_PG_FETCH) && wr_valid)
                byte_q <= wr_data;
            if (vfy_hit) begin
                if (!vfy_ok) begin
                    pass_q <= 1'b0;
                    fail_q <= addr_q;
                end else if (last_c) begin
                    chip_q <= first_c;
                    addr_q <= addr_q + 1'b1;
                    if (st_q == ST_PG_VFY)
                        left_q <= left_q - 1'b1;
                end else begin
                    chip_q <= next_c;
                end
            end
        end
    end

    // pin and handshake outputs
    always_comb begin
        dev_ce_n  = '1;
        dev_oe_n  = 1'b1;
        dev_pgm_n = 1'b1;
        dev_addr  = addr_q;
        drv_en    = 1'b0;
        dout      = byte_q;
        vpp_req   = 1'b0;
        a9hv_req  = 1'b0;
        cmd_ready = 1'b0;
        wr_ready  = 1'b0;
        done      = 1'b0;
        unique case (st_q)
            ST_IDLE: cmd_ready = 1'b1;
            ST_ER_RAMP, ST_ER_PULSE: begin
                vpp_req   = 1'b1;
                a9hv_req  = 1'b1;
                dev_ce_n  = ~mask_q;
                dev_addr  = '0;
                drv_en    = 1'b1;
                dout      = '1;
                dev_pgm_n = (st_q != ST_ER_PULSE);
            end
            ST_ER_SETTLE: begin
                vpp_req  = 1'b1;
                dev_ce_n = ~mask_q;
                dev_addr = '0;
                drv_en   = 1'b1;
                dout     = '1;
            end
            ST_ER_VFY, ST_PG_VFY: begin
                vpp_req  = 1'b1;
                dev_ce_n = ~(NUM_CHIPS'(1) << chip_q);
                dev_oe_n = 1'b0;
            end
            ST_PG_RAMP: vpp_req = 1'b1;
            ST_PG_FETCH: begin
                vpp_req  = 1'b1;
                wr_ready = 1'b1;
            end
            ST_PG_SETUP, ST_PG_PULSE: begin
                vpp_req   = 1'b1;
                dev_ce_n  = ~mask_q;
                drv_en    = 1'b1;
                dev_pgm_n = (st_q != ST_PG_PULSE);
            end
            ST_PG_SETTLE: begin
                vpp_req  = 1'b1;
                dev_ce_n = ~mask_q;
            end
            ST_RAMPDN: ;
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

    assign dev_data  = drv_en ? dout : {DATA_W{1'bz}};
    assign pass      = pass_q;
    assign fail_addr = fail_q;

endmodule

// File: rtl/eprom_seq_chk.sv
module eprom_seq_chk #(
    parameter int ADDR_W    = 17,
    parameter int DATA_W    = 8,
    parameter int NUM_CHIPS = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cmd_ready,
    input logic                 done,
    input logic [NUM_CHIPS-1:0] dev_ce_n,
    input logic                 dev_oe_n,
    input logic                 dev_pgm_n,
    input logic [ADDR_W-1:0]    dev_addr,
    input logic [DATA_W-1:0]    dev_data,
    input logic                 vpp_req,
    input logic                 a9hv_req,
    input logic                 hv_ack,
    input logic                 drv_en,
    input logic [NUM_CHIPS-1:0] mask_q
);

    AST_ERASE_PIN_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_pgm_n && a9hv_req) |-> (vpp_req && dev_oe_n && dev_addr == '0 && dev_data == '1 && (dev_ce_n == ~mask_q))); // R1
    AST_A9_WITH_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        a9hv_req |-> vpp_req); // R1
    AST_STROBE_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_pgm_n |-> (vpp_req && hv_ack)); // R10
    AST_READ_ONE_CHIP: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_oe_n |-> (dev_pgm_n && $countones(~dev_ce_n) == 1)); // R5
    AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_oe_n |-> !drv_en); // R6
    AST_INHIBIT_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        ((~dev_ce_n) & (~mask_q)) == '0); // R7
    AST_DONE_SUPPLY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!vpp_req && !a9hv_req)); // R9
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_READY_QUIET_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (dev_ce_n == '1 && dev_pgm_n && dev_oe_n)); // R13

endmodule

bind eprom_prog_seq eprom_seq_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CHIPS(NUM_CHIPS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_ready (cmd_ready),
    .done      (done),
    .dev_ce_n  (dev_ce_n),
    .dev_oe_n  (dev_oe_n),
    .dev_pgm_n (dev_pgm_n),
    .dev_addr  (dev_addr),
    .dev_data  (dev_data),
    .vpp_req   (vpp_req),
    .a9hv_req  (a9hv_req),
    .hv_ack    (hv_ack),
    .drv_en    (drv_en),
    .mask_q    (mask_q)
);

// File: tb/sim_eprom_prog_seq.sv
`timescale 1ns/1ps
module sim_eprom_prog_seq;

    localparam int AW   = 6;
    localparam int DW   = 8;
    localparam int NC   = 2;
    localparam int ECYC = 40;
    localparam int PCYC = 5;
    localparam int ACYC = 2;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic          cmd_op = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [AW:0]   cmd_len = '0;
    logic [NC-1:0] cmd_chips = '0;
    logic          wr_valid;
    logic          wr_ready;
    logic [DW-1:0] wr_data;
    logic          done, pass;
    logic [AW-1:0] fail_addr;
    logic [NC-1:0] dev_ce_n;
    logic          dev_oe_n, dev_pgm_n;
    logic [AW-1:0] dev_addr;
    wire  [DW-1:0] dev_data;
    logic          vpp_req, a9hv_req, hv_ack;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    eprom_prog_seq #(
        .ADDR_W(AW), .DATA_W(DW), .NUM_CHIPS(NC),
        .ERASE_CYC(ECYC), .PROG_CYC(PCYC), .ACC_CYC(ACYC)
    ) u0 (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_chips(cmd_chips),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .done(done), .pass(pass), .fail_addr(fail_addr),
        .dev_ce_n(dev_ce_n), .dev_oe_n(dev_oe_n), .dev_pgm_n(dev_pgm_n),
        .dev_addr(dev_addr), .dev_data(dev_data),
        .vpp_req(vpp_req), .a9hv_req(a9hv_req), .hv_ack(hv_ack)
    );

    // ---------------- host byte stream ----------------
    logic [DW-1:0] wq [0:15];
    int wn = 0;
    int widx = 0;
    assign wr_valid = (widx < wn);
    assign wr_data  = wq[widx[3:0]];
    always @(posedge clk) if (wr_valid && wr_ready) widx <= widx + 1;

    // ---------------- supply model ----------------
    logic [2:0] ack_sr = '0;
    always @(posedge clk) ack_sr <= {ack_sr[1:0], (vpp_req | a9hv_req)};
    assign hv_ack = ack_sr[2];

    // ---------------- device array model ----------------
    logic [DW-1:0] mem [0:NC-1][0:DEPTH-1];
    logic          pgm_prev = 1'b1;
    logic          stuck_en = 1'b0;
    int            stuck_c = 0;
    int            stuck_a = 0;
    int            acc_cnt = 0;
    logic          mdl_drv;
    int            rd_c;
    logic [DW-1:0] mdl_q;

    always @(posedge clk) begin
        pgm_prev <= dev_pgm_n;
        if (!dev_pgm_n && pgm_prev) begin
            for (int c = 0; c < NC; c++) begin
                if (!dev_ce_n[c]) begin
                    if (a9hv_req && vpp_req && dev_addr == '0 && dev_data == 8'hFF) begin
                        for (int a = 0; a < DEPTH; a++) mem[c][a] = 8'hFF;
                        if (stuck_en && stuck_c == c) mem[c][stuck_a] = 8'hEF;
                    end else if (vpp_req) begin
                        mem[c][dev_addr] = mem[c][dev_addr] & dev_data;
                    end
                end
            end
        end
    end

    always @(dev_ce_n or dev_oe_n or dev_addr) acc_cnt = 0;
    always @(posedge clk) if (!dev_oe_n) acc_cnt = acc_cnt + 1;

    assign mdl_drv  = !dev_oe_n && (dev_ce_n != '1);
    assign rd_c     = dev_ce_n[0] ? 1 : 0;
    assign mdl_q    = (acc_cnt >= ACYC - 1) ? mem[rd_c][dev_addr] : 8'h5A;
    assign dev_data = mdl_drv ? mdl_q : {DW{1'bz}};

    // ---------------- strobe / supply monitors ----------------
    int   pw_cur = 0, n_pulse = 0, pw_min = 0, pw_max = 0;
    logic vpp_seen = 1'b0;
    always @(posedge clk) begin
        if (vpp_req) vpp_seen <= 1'b1;
        if (!dev_pgm_n) pw_cur <= pw_cur + 1;
        else if (pw_cur != 0) begin
            n_pulse <= n_pulse + 1;
            if (n_pulse == 0 || pw_cur < pw_min) pw_min <= pw_cur;
            if (pw_cur > pw_max) pw_max <= pw_cur;
            pw_cur <= 0;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clr_monitors();
        @(negedge clk);
        n_pulse = 0; pw_min = 0; pw_max = 0; vpp_seen = 1'b0;
    endtask

    task automatic issue(input logic op, input int addr, input int len, input logic [NC-1:0] chips);
        @(negedge clk);
        cmd_op = op; cmd_addr = AW'(addr); cmd_len = (AW+1)'(len); cmd_chips = chips;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(cmd_ready == 1'b0, "R13 busy", int'(cmd_ready), 0);
    endtask

    task automatic wait_done(output bit got);
        got = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (done) begin got = 1'b1; break; end
        end
        chk(got, "R9 done seen", int'(got), 1);
        chk(!vpp_req && !a9hv_req, "R9 requests low at done", int'({vpp_req, a9hv_req}), 0);
        @(negedge clk);
        chk(done == 1'b0, "R9 done single cycle", int'(done), 0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk(cmd_ready == 1'b1 && done == 1'b0, "R12 handshake", int'({cmd_ready, done}), 2);
        chk(dev_pgm_n && dev_oe_n && dev_ce_n == '1, "R12 pins", int'({dev_pgm_n, dev_oe_n, dev_ce_n}), 15);
        chk(!vpp_req && !a9hv_req, "R12 requests", int'({vpp_req, a9hv_req}), 0);
    endtask

    task automatic t_erase_ok();
        bit got; int bad = 0;
        clr_monitors();
        issue(1'b0, 0, 0, 2'b11);
        wait_done(got);
        chk(pass == 1'b1, "R3 erase pass", int'(pass), 1);
        chk(n_pulse == 1, "R2 erase pulse count", n_pulse, 1);
        chk(pw_max == ECYC && pw_min == ECYC, "R2 erase width", pw_max, ECYC);
        for (int c = 0; c < NC; c++)
            for (int a = 0; a < DEPTH; a++) if (mem[c][a] != 8'hFF) bad++;
        chk(bad == 0, "R1 both chips erased", bad, 0);
    endtask

    task automatic t_prog_single();
        bit got; int bad = 0; int bad1 = 0;
        logic [DW-1:0] d [0:4] = '{8'h12, 8'hA5, 8'h00, 8'h7E, 8'hC3};
        clr_monitors();
        for (int i = 0; i < 5; i++) wq[i] = d[i];
        widx = 0; wn = 5;
        issue(1'b1, 3, 5, 2'b01);
        wait_done(got);
        chk(pass == 1'b1, "R4 program pass", int'(pass), 1);
        for (int i = 0; i < 5; i++) if (mem[0][3+i] != d[i]) bad++;
        chk(bad == 0, "R4 chip0 contents", bad, 0);
        for (int a = 0; a < DEPTH; a++) if (mem[1][a] != 8'hFF) bad1++;
        chk(bad1 == 0, "R7 chip1 inhibited", bad1, 0);
        chk(n_pulse == 5 && pw_max == PCYC && pw_min == PCYC, "R2 program pulses", n_pulse * 100 + pw_max, 500 + PCYC);
        chk(widx == 5, "R4 stream consumed", widx, 5);
    endtask

    task automatic t_prog_gang();
        bit got; int bad = 0;
        logic [DW-1:0] d [0:3] = '{8'h81, 8'h42, 8'h24, 8'h18};
        clr_monitors();
        for (int i = 0; i < 4; i++) wq[i] = d[i];
        widx = 0; wn = 4;
        issue(1'b1, 60, 4, 2'b11);
        wait_done(got);
        chk(pass == 1'b1, "R4 gang pass", int'(pass), 1);
        for (int c = 0; c < NC; c++)
            for (int i = 0; i < 4; i++) if (mem[c][60+i] != d[i]) bad++;
        chk(bad == 0, "R4 gang contents", bad, 0);
        chk(n_pulse == 4, "R2 gang one pulse per byte", n_pulse, 4);
    endtask

    task automatic t_prog_fail();
        bit got;
        clr_monitors();
        wq[0] = 8'h34; wq[1] = 8'h55;
        widx = 0; wn = 2;
        issue(1'b1, 3, 2, 2'b01);
        wait_done(got);
        chk(pass == 1'b0, "R8 program mismatch flagged", int'(pass), 0);
        chk(fail_addr == 6'd3, "R8 fail address", int'(fail_addr), 3);
        chk(widx == 1, "R8 no further bytes taken", widx, 1);
        chk(n_pulse == 1, "R8 no retry", n_pulse, 1);
        chk(mem[0][3] == 8'h10, "R4 bits only clear", int'(mem[0][3]), 'h10);
        wn = 0; widx = 0;
    endtask

    task automatic t_noop();
        bit got;
        clr_monitors();
        issue(1'b1, 5, 0, 2'b11);
        wait_done(got);
        chk(pass == 1'b1 && n_pulse == 0 && !vpp_seen, "R11 zero length", int'({pass, vpp_seen}) + n_pulse * 4, 2);
        clr_monitors();
        issue(1'b0, 0, 0, 2'b00);
        wait_done(got);
        chk(pass == 1'b1 && n_pulse == 0 && !vpp_seen, "R11 empty mask", int'({pass, vpp_seen}) + n_pulse * 4, 2);
    endtask

    task automatic t_erase_fail();
        bit got;
        stuck_en = 1'b1; stuck_c = 1; stuck_a = 10;
        clr_monitors();
        issue(1'b0, 0, 0, 2'b11);
        wait_done(got);
        chk(pass == 1'b0, "R3 erase defect flagged", int'(pass), 0);
        chk(fail_addr == 6'd10, "R8 erase fail address", int'(fail_addr), 10);
        chk(n_pulse == 1, "R8 erase no retry", n_pulse, 1);
        stuck_en = 1'b0;
    endtask

    // ---------------- run ----------------
    initial begin
        for (int c = 0; c < NC; c++)
            for (int a = 0; a < DEPTH; a++) mem[c][a] = DW'(a * 7 + c * 3 + 1);
        for (int i = 0; i < 16; i++) wq[i] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_erase_ok();
        t_prog_single();
        t_prog_gang();
        t_prog_fail();
        t_noop();
        t_erase_fail();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule